// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block lays a 32x32 two-colour cursor over a stream of already coloured pixels. Each incoming pixel carries its screen coordinate and a 24-bit base colour. If the pixel falls inside the cursor window, and the cursor's mask bit for that spot is set, the block replaces the base colour with one of two overlay colours. Those two colours are supplied on input pins by the palette logic that sits beside this block. All other pixels pass through unchanged, one cycle later.

The cursor is defined over a plain 32-bit register port, with writes strobed and reads combinational on the address. One register sets the cursor position: the upper half of the word is the column and the lower half is the line. Two banks of 32 row words hold the mask and the colour select. A general-purpose control word can be written and read back.

The pixel path is valid/ready on both sides. The output stage holds one pixel. A new pixel is taken whenever that stage is empty or is being drained in the same cycle (`pix_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output pixel and its valid flag stay frozen and `pix_ready` is low. The overlay colours and the cursor registers are sampled at the edge where a pixel is accepted.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, both cursor coordinates are 0xF000, all mask and select rows are zero, `out_valid` is low, and every pixel accepted before any register write leaves with its base colour.
- R2: A write to byte offset 0x8FC loads the cursor column from data bits 31:16 and the cursor line from bits 15:0. It acts on pixels accepted after that write's clock edge; a pixel accepted at the same edge uses the previous position.
- R3: A write to offset 0x900+4r loads mask row r, and a write to 0x980+4r loads select row r, for r from 0 to 31. Row r applies to screen line cursor-line + r.
- R4: Within a row word, bit 31 is the pixel at the cursor column and bit 31-k is the pixel k columns to its right, for k from 0 to 31.
- R5: Where the mask bit is 1, the output is `ovl_c1` if the select bit is 1 and `ovl_c0` if it is 0. Where the mask bit is 0, the base colour passes.
- R6: Pixels with x at or beyond SCR_W, or y at or beyond SCR_H, always pass their base colour. When the cursor column is at or beyond SCR_W, nothing is drawn.
- R7: Pixels left of the cursor column, more than 31 columns right of it, above the cursor line, or more than 31 lines below it pass their base colour. This includes cursor positions near 0xFFFF, which must not wrap onto the top-left of the screen.
- R8: Offset 0x818 is a read/write control word; its read value always has bit 25 set. Reading any other offset, including position, mask and select, returns zero.
- R9: A pixel accepted at a clock edge appears on `out_rgb` with `out_valid` high straight after that edge, and `out_valid` falls after a drain edge at which no pixel was accepted.
- R10: `pix_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_rgb` hold.
- R11: Writes to offsets outside 0x818, 0x8FC and the two row banks change neither the control word nor the drawn cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ovl_c0 | input | 24 | Overlay colour for mask=1, select=0 |
| ovl_c1 | input | 24 | Overlay colour for mask=1, select=1 |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Block can take an input pixel |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel line |
| pix_rgb | input | 24 | Input pixel base colour |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink takes the output pixel |
| out_rgb | output | 24 | Output pixel colour |

## Verification
The collision that matters is a position write landing on the same edge at which a pixel is accepted inside both the old and the new cursor window. The bench drives the write strobe and the pixel together in one cycle. It expects the old-position colour for that pixel and the new-position colour for the pixel that follows. A second overlap is a stalled output stage while new pixels queue at the input: random sink back-pressure runs during a full cursor scan, and the scoreboard must still see every colour in order.

// File: rtl/cur_pkg.sv
`timescale 1ns/1ps
package cur_pkg;
  localparam int unsigned AW = 12;   // register byte-offset width
  localparam int unsigned DW = 32;   // register word and cursor row width
  localparam int unsigned CW = 16;   // coordinate width
  localparam int unsigned PW = 24;   // pixel colour width

  localparam logic [AW-1:0] OFS_CTRL = 12'h818;
  localparam logic [AW-1:0] OFS_POS  = 12'h8FC;
  localparam logic [AW-1:0] OFS_MASK = 12'h900;
  localparam logic [AW-1:0] OFS_SEL  = 12'h980;

  localparam int unsigned   CTRL_ONE_BIT = 25;
  localparam logic [CW-1:0] POS_PARK     = 16'hF000;
endpackage

// File: rtl/cur_regs.sv
`timescale 1ns/1ps
// Register decode and cursor storage.
module cur_regs
  import cur_pkg::*;
#(
  parameter int unsigned ROWS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic [CW-1:0]        cur_x,
  output logic [CW-1:0]        cur_y,
  output logic [ROWS*DW-1:0]   mask_flat,
  output logic [ROWS*DW-1:0]   sel_flat
);
  localparam int unsigned RW   = $clog2(ROWS);
  localparam logic [AW-1:0] SPAN = AW'(ROWS * 4);

  logic [DW-1:0] ctrl_q;
  logic [AW-1:0] mofs, sofs;
  logic          in_mask, in_sel;
  logic [RW-1:0] mrow, srow;

  assign mofs    = reg_addr - OFS_MASK;
  assign sofs    = reg_addr - OFS_SEL;
  assign in_mask = (reg_addr >= OFS_MASK) && (mofs < SPAN);
  assign in_sel  = (reg_addr >= OFS_SEL)  && (sofs < SPAN);
  assign mrow    = mofs[RW+1:2];
  assign srow    = sofs[RW+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x  <= POS_PARK;
      cur_y  <= POS_PARK;
      ctrl_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_POS) begin
        cur_x <= reg_wdata[31:16];
        cur_y <= reg_wdata[15:0];
      end
      if (reg_addr == OFS_CTRL) ctrl_q <= reg_wdata;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [DW-1:0] m_q, s_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m_q <= '0;
        s_q <= '0;
      end else if (reg_wr) begin
        if (in_mask && mrow == RW'(r)) m_q <= reg_wdata;
        if (in_sel  && srow == RW'(r)) s_q <= reg_wdata;
      end
    end
    assign mask_flat[r*DW +: DW] = m_q;
    assign sel_flat[r*DW +: DW]  = s_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL) begin
      reg_rdata = ctrl_q;
      reg_rdata[CTRL_ONE_BIT] = 1'b1;
    end
  end

  // R2
  pos_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_POS) |=>
      (cur_x == $past(reg_wdata[31:16]) && cur_y == $past(reg_wdata[15:0])));

  // R11
  pos_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr || reg_addr != OFS_POS) |=> ($stable(cur_x) && $stable(cur_y)));
endmodule

// File: rtl/cur_hit.sv
`timescale 1ns/1ps
// Window test, screen clipping and bit pick for one pixel.
module cur_hit
  import cur_pkg::*;
#(
  parameter int unsigned SCR_W = 1024,
  parameter int unsigned SCR_H = 768,
  parameter int unsigned ROWS  = 32
) (
  input  logic [CW-1:0]      in_x,
  input  logic [CW-1:0]      in_y,
  input  logic [CW-1:0]      cur_x,
  input  logic [CW-1:0]      cur_y,
  input  logic [ROWS*DW-1:0] mask_flat,
  input  logic [ROWS*DW-1:0] sel_flat,
  output logic               hit,
  output logic               pick_hi
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam int unsigned IW = $clog2(DW);
  localparam logic [CW-1:0] W_LIM = CW'(SCR_W);
  localparam logic [CW-1:0] H_LIM = CW'(SCR_H);
  localparam logic [CW-1:0] C_LIM = CW'(DW);
  localparam logic [CW-1:0] R_LIM = CW'(ROWS);

  logic [CW:0]   dx, dy;
  logic          in_col, in_row, on_scr;
  logic [RW-1:0] row;
  logic [IW-1:0] bitpos;
  logic [DW-1:0] mword, sword;

  assign dx     = {1'b0, in_x} - {1'b0, cur_x};
  assign dy     = {1'b0, in_y} - {1'b0, cur_y};
  assign in_col = !dx[CW] && (dx[CW-1:0] < C_LIM);
  assign in_row = !dy[CW] && (dy[CW-1:0] < R_LIM);
  assign on_scr = (cur_x < W_LIM) && (in_x < W_LIM) && (in_y < H_LIM);
  assign row    = dy[RW-1:0];
  assign bitpos = IW'(DW - 1) - dx[IW-1:0];
  assign mword  = mask_flat[row*DW +: DW];
  assign sword  = sel_flat[row*DW +: DW];
  assign hit     = on_scr && in_col && in_row && mword[bitpos];
  assign pick_hi = sword[bitpos];
endmodule

// File: rtl/ovl_stage.sv
`timescale 1ns/1ps
// Single output register with valid/ready flow control.
module ovl_stage
  import cur_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          hit,
  input  logic          pick_hi,
  input  logic [PW-1:0] base_rgb,
  input  logic [PW-1:0] col_lo,
  input  logic [PW-1:0] col_hi,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_rgb
);
  logic [PW-1:0] pick;

  assign in_ready = !out_valid || out_ready;
  assign pick     = hit ? (pick_hi ? col_hi : col_lo) : base_rgb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_rgb <= pick;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

  // R9
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
  import cur_pkg::*;
#(
  parameter int unsigned SCR_W = 1024,
  parameter int unsigned SCR_H = 768,
  parameter int unsigned ROWS  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [23:0]   ovl_c0,
  input  logic [23:0]   ovl_c1,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [15:0]   pix_x,
  input  logic [15:0]   pix_y,
  input  logic [23:0]   pix_rgb,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [23:0]   out_rgb
);
  localparam logic [CW-1:0] W_LIM = CW'(SCR_W);

  logic [CW-1:0]      cur_x, cur_y;
  logic [ROWS*DW-1:0] mask_flat, sel_flat;
  logic               hit, pick_hi;

  cur_regs #(.ROWS(ROWS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_x(cur_x),
    .cur_y(cur_y), .mask_flat(mask_flat), .sel_flat(sel_flat)
  );

  cur_hit #(.SCR_W(SCR_W), .SCR_H(SCR_H), .ROWS(ROWS)) u_hit (
    .in_x(pix_x), .in_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
    .mask_flat(mask_flat), .sel_flat(sel_flat), .hit(hit), .pick_hi(pick_hi)
  );

  ovl_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_ready(pix_ready),
    .hit(hit), .pick_hi(pick_hi), .base_rgb(pix_rgb), .col_lo(ovl_c0),
    .col_hi(ovl_c1), .out_valid(out_valid), .out_ready(out_ready),
    .out_rgb(out_rgb)
  );

  // R8
  ctrl_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_CTRL) |-> reg_rdata[CTRL_ONE_BIT]);

  // R6
  clip_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_x >= W_LIM) |=> (out_rgb == $past(pix_rgb)));
endmodule

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
  localparam int W = 1024;
  localparam int H = 768;
  localparam logic [23:0] C0 = 24'h123456;
  localparam logic [23:0] C1 = 24'hFEDCBA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [15:0] pix_x = '0, pix_y = '0;
  logic [23:0] pix_rgb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_rgb;

  int total = 0, bad = 0;
  bit bp_mode = 1'b0;
  bit hold_rdy = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] m_mask [32];
  logic [31:0] m_sel  [32];
  logic [15:0] m_x, m_y;
  logic [31:0] m_ctrl;

  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;   // 8 ns period, 125 MHz

  cursor_overlay u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovl_c0(C0), .ovl_c1(C1),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x),
    .pix_y(pix_y), .pix_rgb(pix_rgb), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb)
  );

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_mode ? lfsr[0] : hold_rdy;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model(int x, int y, logic [23:0] b);
    int dx, dy;
    dx = x - int'(m_x);
    dy = y - int'(m_y);
    if (int'(m_x) >= W || x >= W || y >= H) return b;
    if (dx < 0 || dx > 31 || dy < 0 || dy > 31) return b;
    if (m_mask[dy][31-dx]) return m_sel[dy][31-dx] ? C1 : C0;
    return b;
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R9 act=%h exp=none (unexpected output)", out_rgb);
        end else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {8'h0, out_rgb}, {8'h0, e});
        end
      end
    end
  end

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 12'h8FC) begin m_x = d[31:16]; m_y = d[15:0]; end
    if (a == 12'h818) m_ctrl = d;
    if (a >= 12'h900 && a < 12'h980) m_mask[(a - 12'h900) >> 2] = d;
    if (a >= 12'h980 && a < 12'hA00) m_sel[(a - 12'h980) >> 2] = d;
  endtask

  task automatic reg_check(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, e);
  endtask

  task automatic send_pix(int x, int y, logic [23:0] b, string tag);
    bit acc;
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_rgb = b;
    exp_q.push_back(model(x, y, b));
    tag_q.push_back(tag);
    do begin
      #1 acc = pix_ready;
      @(negedge clk);
    end while (!acc);
    pix_valid = 1'b0;
  endtask

  task automatic scan(int x0, int x1, int y0, int y1, string tag);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        send_pix(x, y, {x[7:0], y[7:0], 8'h5A}, tag);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R10 drain", exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin m_mask[r] = '0; m_sel[r] = '0; end
    m_x = 16'hF000; m_y = 16'hF000; m_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 out_valid", {31'b0, out_valid}, 0);
    chk("R10 ready idle", {31'b0, pix_ready}, 1);
    reg_check(12'h818, 32'h0200_0000, "R8 ctrl reset");
    scan(0, 3, 0, 1, "R1 parked pass");
    scan(1020, 1023, 766, 767, "R1 parked pass corner");
    drain();

    // R9 latency
    send_pix(10, 10, 24'hABCDEF, "R9 data");
    #1 chk("R9 valid after accept", {31'b0, out_valid}, 1);
    @(negedge clk); #1 chk("R9 valid falls", {31'b0, out_valid}, 0);

    // R3 R4 R5 cursor pattern
    for (int r = 0; r < 32; r++) begin
      reg_write(12'(12'h900 + 4*r), 32'hF00F_A5C3 ^ (32'h0101_0101 * r));
      reg_write(12'(12'h980 + 4*r), 32'h3355_CCAA ^ (32'h0010_0401 * r));
    end
    reg_write(12'h900, 32'h8000_0001);   // R4 leftmost and rightmost bits
    reg_write(12'h980, 32'h8000_0000);
    reg_write(12'h8FC, {16'd200, 16'd100});
    reg_check(12'h8FC, 32'h0, "R8 pos reads zero");
    reg_check(12'h900, 32'h0, "R8 mask reads zero");
    reg_check(12'h9FC, 32'h0, "R8 sel reads zero");
    send_pix(200, 100, 24'h111111, "R4 bit31 c1");
    send_pix(231, 100, 24'h111111, "R5 bit0 c0");
    send_pix(201, 100, 24'h222222, "R5 mask0 base");
    scan(196, 235, 98, 133, "R3 R5 R7 scan");
    drain();

    // R10 stall behaviour
    hold_rdy = 1'b0;
    repeat (2) @(negedge clk);
    send_pix(200, 100, 24'h333333, "R10 stalled pixel");
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R10 valid held", {31'b0, out_valid}, 1);
      chk("R10 ready low", {31'b0, pix_ready}, 0);
      chk("R10 data held", {8'h0, out_rgb}, {8'h0, C1});
      @(negedge clk);
    end
    hold_rdy = 1'b1;
    drain();

    // R10 random back-pressure over a scan
    bp_mode = 1'b1;
    scan(198, 233, 99, 132, "R10 bp scan");
    bp_mode = 1'b0;
    drain();

    // R2 same-edge write and pixel
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h8FC; reg_wdata = {16'd201, 16'd100};
    pix_valid = 1'b1; pix_x = 16'd200; pix_y = 16'd100; pix_rgb = 24'h444444;
    exp_q.push_back(model(200, 100, 24'h444444));
    tag_q.push_back("R2 same edge old pos");
    @(negedge clk);
    reg_wr = 1'b0; pix_valid = 1'b0;
    m_x = 16'd201; m_y = 16'd100;
    send_pix(200, 100, 24'h444444, "R2 new pos");
    send_pix(201, 100, 24'h444444, "R2 new pos hit");
    drain();

    // R6 clipping at the right edge and height
    reg_write(12'h8FC, {16'd1010, 16'd740});
    scan(1004, 1030, 740, 741, "R6 right clip");
    scan(1008, 1012, 766, 770, "R6 bottom clip");
    reg_write(12'h8FC, {16'd1024, 16'd10});
    scan(1020, 1030, 10, 11, "R6 cursor off width");
    drain();

    // R7 no wrap near 0xFFFF
    reg_write(12'h8FC, {16'hFFF0, 16'hFFF0});
    scan(0, 20, 0, 3, "R7 no wrap");
    reg_write(12'h8FC, {16'd0, 16'd0});
    scan(0, 33, 30, 33, "R7 top-left window edge");
    drain();

    // R8 control word
    reg_write(12'h818, 32'h00C0_FFEE);
    reg_check(12'h818, 32'h02C0_FFEE, "R8 ctrl readback");
    // R11 writes elsewhere ignored
    reg_write(12'h81C, 32'hFFFF_FFFF); m_ctrl = m_ctrl;
    reg_write(12'h8F8, 32'hFFFF_FFFF);
    reg_write(12'hA00, 32'hFFFF_FFFF);
    reg_write(12'h000, 32'hFFFF_FFFF);
    reg_check(12'h818, 32'h02C0_FFEE, "R11 ctrl unchanged");
    reg_check(12'h81C, 32'h0, "R8 other offset zero");
    scan(0, 33, 0, 2, "R11 cursor unchanged");
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule